// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits between five interrupt sources and a CPU core. The sources are two external request lines, two timer overflow strobes and one serial channel. The serial channel folds its receive-done and transmit-done events into a single request. The controller qualifies each request with a master enable and a per-source enable. It sorts each qualified request into a low or high level using a one-bit-per-source priority setting. It then presents one request to the core together with the 16-bit address of the handler.

The core answers with an acknowledge, which marks the granted level as being in service. The core ends the handler with a return strobe, which retires the highest level that is active. While a low-level handler runs, only a high-level source can interrupt it. While a high-level handler runs, no new request is forwarded. Software programs the enable and priority settings, and clears the serial event flags, through a small register port with a combinational read.

The external line 0 is captured on its rising edge by default, and external line 1 is sampled as a level. A parameter selects the capture style for each external line.

Top module: `icu_vectored_irq`

## Requirements
- R1: After a synchronous reset, all registers read 0, `irq_req_o` is 0 and `irq_vec_o` is 0x0000.
- R2: The register port decodes `reg_addr_i` as follows. Address 0 is the enable register: bit 7 is the master enable and bits 4:0 are the source enables, while bits 6:5 always read 0. Address 1 is the priority register: bits 4:0 are writable and bits 7:5 read 0. Address 2 is the serial flag register: bit 0 is the receive flag and bit 1 is the transmit flag, and writing a 1 to a bit clears that bit. Address 3 reads 0.
- R3: While the master enable (enable bit 7) is 0, `irq_req_o` stays 0 whatever the source enables are.
- R4: A source whose enable bit is 0 is never forwarded. The bit positions are: 0 for external 0, 1 for timer 0, 2 for external 1, 3 for timer 1 and 4 for serial.
- R5: The vector is 0x0003 for external 0, 0x000B for timer 0, 0x0013 for external 1, 0x001B for timer 1 and 0x0023 for serial. It is 0x0000 when no request is forwarded.
- R6: When several requests of the same level are pending, the lowest bit position wins.
- R7: A priority bit of 1 puts that source in the high level. A high-level request is forwarded ahead of any low-level request.
- R8: While a low-level service is active, only high-level requests are forwarded. While a high-level service is active, nothing is forwarded.
- R9: An acknowledge while `irq_req_o` is 1 marks the granted level as in service. It clears the pending flag of a granted timer source or of a granted edge-captured external source. A level-sampled external source keeps requesting for as long as its input is high.
- R10: A strobe on `ser_rx_done_i` or `ser_tx_done_i` sets its serial flag. An acknowledge does not clear the serial flags. Only a register write clears them, and a new event in the same cycle as a clearing write wins over the clear.
- R11: A return strobe clears the high in-service level if it is set, and otherwise clears the low level.
- R12: An edge-captured external source becomes pending on the rising edge of its input, one clock later. An input that is simply held high does not re-arm it after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_i | input | 2 | External request lines 0 and 1 |
| tmr_ovf_i | input | 2 | Timer 0 and timer 1 overflow strobes |
| ser_rx_done_i | input | 1 | Serial receive-done strobe |
| ser_tx_done_i | input | 1 | Serial transmit-done strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 16 | Handler address of the forwarded source |
| irq_ack_i | input | 1 | Core acknowledge of the current request |
| irq_reti_i | input | 1 | Return-from-interrupt strobe |

## Verification
A stuck or lost in-service bit shows up at the ports within one cycle of the next qualifying request. Depending on the fault, a request stays silent when it should appear, or a low-level source reaches the core during a handler.

A pending flag that is not cleared on acknowledge makes the same vector reappear one cycle after the return strobe. A flag that is cleared when it should not be, as with the serial flags, makes the request vanish and changes the read of register 2 at once.

A wrong arbitration choice shows up in the same cycle as a wrong vector value. The bench therefore compares the request, the vector and the read data against a reference model on every cycle.

// File: rtl/icu_pkg.sv
package icu_pkg;

    localparam int NSRC   = 5;
    localparam int IDX_W  = 3;
    localparam int REG_W  = 8;
    localparam int VEC_W  = 16;
    localparam int EA_BIT = 7;

    localparam logic [REG_W-1:0] EN_MASK = 8'h9F;
    localparam logic [VEC_W-1:0] VEC_BASE = 16'h0003;
    localparam int VEC_SHIFT = 3;

    typedef enum logic [IDX_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4
    } src_e;

    typedef enum logic [1:0] {
        RA_ENABLE = 2'd0,
        RA_PRIO   = 2'd1,
        RA_SERIAL = 2'd2,
        RA_NONE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             valid;
        logic             high;
        logic [IDX_W-1:0] idx;
    } grant_t;

    function automatic logic [VEC_W-1:0] vector_of(logic [IDX_W-1:0] idx);
        return VEC_BASE + {{(VEC_W-IDX_W-VEC_SHIFT){1'b0}}, idx, {VEC_SHIFT{1'b0}}};
    endfunction

    function automatic logic [IDX_W-1:0] first_set(logic [NSRC-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/icu_src_capture.sv
module icu_src_capture
    import icu_pkg::*;
#(
    parameter logic [1:0] EXT_EDGE = 2'b01
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      ext_i,
    input  logic [1:0]      tmr_ovf_i,
    input  logic            ser_rx_i,
    input  logic            ser_tx_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic [1:0]      ser_w1c_i,
    output logic [NSRC-1:0] req_o,
    output logic [1:0]      ser_flags_o
);

    logic [1:0] ser_q;

    for (genvar g = 0; g < 2; g++) begin : g_pair
        if (EXT_EDGE[g]) begin : g_edge
            logic prev_q;
            logic flag_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q <= 1'b0;
                    flag_q <= 1'b0;
                end else begin
                    prev_q <= ext_i[g];
                    if (ext_i[g] && !prev_q)
                        flag_q <= 1'b1;
                    else if (clr_i[2*g])
                        flag_q <= 1'b0;
                end
            end
            assign req_o[2*g] = flag_q;

            a_r12_rise_arms: assert property (@(posedge clk) disable iff (rst)
                (ext_i[g] && !prev_q) |=> req_o[2*g]);
            a_r9_edge_ack_clears: assert property (@(posedge clk) disable iff (rst)
                (clr_i[2*g] && !(ext_i[g] && !prev_q)) |=> !req_o[2*g]);
        end else begin : g_level
            assign req_o[2*g] = ext_i[g];

            a_r9_level_grant_needs_input: assert property (@(posedge clk) disable iff (rst)
                clr_i[2*g] |-> ext_i[g]);
        end

        logic tflag_q;
        always_ff @(posedge clk) begin
            if (rst)
                tflag_q <= 1'b0;
            else if (tmr_ovf_i[g])
                tflag_q <= 1'b1;
            else if (clr_i[2*g+1])
                tflag_q <= 1'b0;
        end
        assign req_o[2*g+1] = tflag_q;

        a_r9_timer_ack_clears: assert property (@(posedge clk) disable iff (rst)
            (clr_i[2*g+1] && !tmr_ovf_i[g]) |=> !req_o[2*g+1]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            ser_q <= '0;
        else
            ser_q <= (ser_q & ~ser_w1c_i) | {ser_tx_i, ser_rx_i};
    end

    assign req_o[SRC_SER] = |ser_q;
    assign ser_flags_o    = ser_q;

    a_r10_ack_keeps_serial: assert property (@(posedge clk) disable iff (rst)
        (clr_i[SRC_SER] && ser_w1c_i == 2'b00) |=> (ser_flags_o != 2'b00));

endmodule

// File: rtl/icu_arbiter.sv
module icu_arbiter
    import icu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] prio_i,
    input  logic            ea_i,
    input  logic            ins_hi_i,
    input  logic            ins_lo_i,
    output grant_t          grant_o
);

    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] hi_set;
    logic [NSRC-1:0] lo_set;

    always_comb begin
        elig   = req_i & en_i & {NSRC{ea_i}};
        hi_set = elig & prio_i;
        lo_set = elig & ~prio_i;
        grant_o = '0;
        if (!ins_hi_i) begin
            if (|hi_set)
                grant_o = '{valid: 1'b1, high: 1'b1, idx: first_set(hi_set)};
            else if (!ins_lo_i && |lo_set)
                grant_o = '{valid: 1'b1, high: 1'b0, idx: first_set(lo_set)};
        end
    end

    a_r3_master_off_silent: assert property (@(posedge clk) disable iff (rst)
        !ea_i |-> !grant_o.valid);
    a_r8_high_busy_silent: assert property (@(posedge clk) disable iff (rst)
        ins_hi_i |-> !grant_o.valid);
    a_r8_low_busy_high_only: assert property (@(posedge clk) disable iff (rst)
        (ins_lo_i && grant_o.valid) |-> grant_o.high);
    a_r4_granted_is_enabled: assert property (@(posedge clk) disable iff (rst)
        grant_o.valid |-> (req_i[grant_o.idx] && en_i[grant_o.idx]));
    a_r7_level_matches_prio: assert property (@(posedge clk) disable iff (rst)
        grant_o.valid |-> (grant_o.high == prio_i[grant_o.idx]));

endmodule

// File: rtl/icu_level_track.sv
module icu_level_track (
    input  logic clk,
    input  logic rst,
    input  logic take_i,
    input  logic take_high_i,
    input  logic reti_i,
    output logic ins_hi_o,
    output logic ins_lo_o
);

    logic hi_q, lo_q, hi_d, lo_d;

    always_comb begin
        hi_d = hi_q;
        lo_d = lo_q;
        if (reti_i) begin
            if (hi_q) hi_d = 1'b0;
            else      lo_d = 1'b0;
        end
        if (take_i) begin
            if (take_high_i) hi_d = 1'b1;
            else             lo_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

    assign ins_hi_o = hi_q;
    assign ins_lo_o = lo_q;

    a_r11_reti_high_first: assert property (@(posedge clk) disable iff (rst)
        (reti_i && hi_q && !take_i) |=> (!hi_q && lo_q == $past(lo_q)));
    a_r11_reti_low_next: assert property (@(posedge clk) disable iff (rst)
        (reti_i && !hi_q && !take_i) |=> !lo_q);
    a_r9_ack_marks_level: assert property (@(posedge clk) disable iff (rst)
        take_i |=> (hi_q || lo_q));

endmodule

// File: rtl/icu_vectored_irq.sv
module icu_vectored_irq
    import icu_pkg::*;
#(
    parameter logic [1:0] EXT_EDGE = 2'b01
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  ext_irq_i,
    input  logic [1:0]  tmr_ovf_i,
    input  logic        ser_rx_done_i,
    input  logic        ser_tx_done_i,
    input  logic [1:0]  reg_addr_i,
    input  logic        reg_wr_i,
    input  logic [7:0]  reg_wdata_i,
    output logic [7:0]  reg_rdata_o,
    output logic        irq_req_o,
    output logic [15:0] irq_vec_o,
    input  logic        irq_ack_i,
    input  logic        irq_reti_i
);

    logic [REG_W-1:0] en_q;
    logic [NSRC-1:0]  prio_q;
    logic [NSRC-1:0]  req;
    logic [NSRC-1:0]  clr;
    logic [1:0]       ser_flags;
    logic [1:0]       ser_w1c;
    logic             ins_hi, ins_lo, take;
    grant_t           grant;
    reg_addr_e        ra;

    assign ra = reg_addr_e'(reg_addr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            prio_q <= '0;
        end else if (reg_wr_i) begin
            if (ra == RA_ENABLE) en_q   <= reg_wdata_i & EN_MASK;
            if (ra == RA_PRIO)   prio_q <= reg_wdata_i[NSRC-1:0];
        end
    end

    assign ser_w1c = (reg_wr_i && ra == RA_SERIAL) ? reg_wdata_i[1:0] : 2'b00;

    always_comb begin
        case (ra)
            RA_ENABLE: reg_rdata_o = en_q;
            RA_PRIO:   reg_rdata_o = {{(REG_W-NSRC){1'b0}}, prio_q};
            RA_SERIAL: reg_rdata_o = {{(REG_W-2){1'b0}}, ser_flags};
            default:   reg_rdata_o = '0;
        endcase
    end

    assign take = irq_ack_i && grant.valid;
    assign clr  = take ? ({{(NSRC-1){1'b0}}, 1'b1} << grant.idx) : '0;

    icu_src_capture #(.EXT_EDGE(EXT_EDGE)) u_capture (
        .clk        (clk),
        .rst        (rst),
        .ext_i      (ext_irq_i),
        .tmr_ovf_i  (tmr_ovf_i),
        .ser_rx_i   (ser_rx_done_i),
        .ser_tx_i   (ser_tx_done_i),
        .clr_i      (clr),
        .ser_w1c_i  (ser_w1c),
        .req_o      (req),
        .ser_flags_o(ser_flags)
    );

    icu_arbiter u_arbiter (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req),
        .en_i    (en_q[NSRC-1:0]),
        .prio_i  (prio_q),
        .ea_i    (en_q[EA_BIT]),
        .ins_hi_i(ins_hi),
        .ins_lo_i(ins_lo),
        .grant_o (grant)
    );

    icu_level_track u_track (
        .clk        (clk),
        .rst        (rst),
        .take_i     (take),
        .take_high_i(grant.high),
        .reti_i     (irq_reti_i),
        .ins_hi_o   (ins_hi),
        .ins_lo_o   (ins_lo)
    );

    assign irq_req_o = grant.valid;
    assign irq_vec_o = grant.valid ? vector_of(grant.idx) : '0;

    a_r5_vector_shape: assert property (@(posedge clk) disable iff (rst)
        irq_req_o |-> (irq_vec_o[2:0] == 3'b011 && irq_vec_o <= 16'h0023));
    a_r5_idle_vector_zero: assert property (@(posedge clk) disable iff (rst)
        !irq_req_o |-> irq_vec_o == 16'h0000);
    a_r2_reserved_bits_zero: assert property (@(posedge clk) disable iff (rst)
        en_q[6:5] == 2'b00);

endmodule

// File: tb/icu_vectored_irq_bench.sv
`timescale 1ns/1ps
module icu_vectored_irq_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  ext_irq, tmr_ovf;
    logic        rx, tx, wr, ack, reti;
    logic [1:0]  addr;
    logic [7:0]  wdata, rdata;
    logic        req;
    logic [15:0] vec;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    icu_vectored_irq u_icu_vectored_irq (
        .clk(clk), .rst(rst), .ext_irq_i(ext_irq), .tmr_ovf_i(tmr_ovf),
        .ser_rx_done_i(rx), .ser_tx_done_i(tx), .reg_addr_i(addr),
        .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_req_o(req), .irq_vec_o(vec), .irq_ack_i(ack), .irq_reti_i(reti)
    );

    // reference model (ext0 edge-captured, ext1 level-sampled)
    logic [7:0] m_en;
    logic [4:0] m_prio, m_flag;
    logic [1:0] m_prev, m_ser;
    logic       m_hi, m_lo;

    function automatic logic [4:0] m_req();
        return {|m_ser, m_flag[3], ext_irq[1], m_flag[1], m_flag[0]};
    endfunction

    function automatic logic [2:0] low_idx(logic [4:0] v);
        for (int i = 0; i < 5; i++) if (v[i]) return 3'(i);
        return 3'd0;
    endfunction

    function automatic logic [4:0] m_grant(); // {valid, high, idx}
        logic [4:0] e, h, l;
        e = m_req() & m_en[4:0] & {5{m_en[7]}};
        h = e & m_prio;
        l = e & ~m_prio;
        if (m_hi) return 5'd0;
        if (|h) return {2'b11, low_idx(h)};
        if (!m_lo && |l) return {2'b10, low_idx(l)};
        return 5'd0;
    endfunction

    function automatic logic [15:0] m_vec();
        logic [4:0] g = m_grant();
        return g[4] ? 16'h0003 + 16'(g[2:0]) * 16'd8 : 16'h0000;
    endfunction

    function automatic logic [7:0] m_read();
        case (addr)
            2'd0:    return m_en;
            2'd1:    return {3'b000, m_prio};
            2'd2:    return {6'd0, m_ser};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic m_reset();
        m_en = 0; m_prio = 0; m_flag = 0; m_prev = 0; m_ser = 0; m_hi = 0; m_lo = 0;
    endtask

    // one clock: compute model next state from present inputs, then compare
    task automatic step();
        logic [4:0] g;
        logic take;
        logic [4:0] nflag;
        logic [1:0] nser;
        logic [7:0] nen;
        logic [4:0] nprio;
        logic nhi, nlo;
        g = m_grant();
        take = ack && g[4];
        nflag = m_flag;
        if (take && (g[2:0] == 3'd0 || g[2:0] == 3'd1 || g[2:0] == 3'd3)) nflag[g[2:0]] = 1'b0;
        if (ext_irq[0] && !m_prev[0]) nflag[0] = 1'b1;
        if (tmr_ovf[0]) nflag[1] = 1'b1;
        if (tmr_ovf[1]) nflag[3] = 1'b1;
        nser = m_ser;
        if (wr && addr == 2'd2) nser = nser & ~wdata[1:0];
        nser = nser | {tx, rx};
        nen = m_en; nprio = m_prio;
        if (wr && addr == 2'd0) nen = wdata & 8'h9F;
        if (wr && addr == 2'd1) nprio = wdata[4:0];
        nhi = m_hi; nlo = m_lo;
        if (reti) begin if (m_hi) nhi = 1'b0; else nlo = 1'b0; end
        if (take) begin if (g[3]) nhi = 1'b1; else nlo = 1'b1; end
        @(posedge clk);
        m_flag = nflag; m_ser = nser; m_en = nen; m_prio = nprio;
        m_hi = nhi; m_lo = nlo; m_prev = ext_irq;
        @(negedge clk);
        chk("R3/R8 model request", 32'(req), 32'(m_grant() >> 4));
        chk("R5 model vector", 32'(vec), 32'(m_vec()));
        chk("R2 model readback", 32'(rdata), 32'(m_read()));
    endtask

    task automatic cyc();
        step();
        wr = 0; ack = 0; reti = 0; tmr_ovf = 0; rx = 0; tx = 0;
    endtask

    task automatic wreg(logic [1:0] a, logic [7:0] d);
        addr = a; wdata = d; wr = 1; cyc();
    endtask

    task automatic expect_irq(string tag, logic r, logic [15:0] v);
        chk({tag, " request"}, 32'(req), 32'(r));
        chk({tag, " vector"}, 32'(vec), 32'(v));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240917);
        rst = 1; ext_irq = 0; tmr_ovf = 0; rx = 0; tx = 0; wr = 0; ack = 0; reti = 0;
        addr = 0; wdata = 0;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        expect_irq("R1 reset", 1'b0, 16'h0000);
        for (int a = 0; a < 4; a++) begin
            addr = 2'(a); #0.1;
            chk("R1 reset register", 32'(rdata), 32'h0);
        end
        // R2 masks
        wreg(2'd0, 8'hFF); addr = 2'd0; #0.1; chk("R2 enable mask", 32'(rdata), 32'h9F);
        wreg(2'd1, 8'hFF); addr = 2'd1; #0.1; chk("R2 priority mask", 32'(rdata), 32'h1F);
        addr = 2'd3; #0.1; chk("R2 unused address", 32'(rdata), 32'h0);
        wreg(2'd1, 8'h00);
        // R3 master enable off
        wreg(2'd0, 8'h1F);
        tmr_ovf = 2'b11; ext_irq[0] = 1'b1; rx = 1'b1; cyc();
        expect_irq("R3 master off", 1'b0, 16'h0000);
        // R6 ordering and R12 edge capture
        wreg(2'd0, 8'h9F);
        expect_irq("R6 R12 ext0 first", 1'b1, 16'h0003);
        ext_irq[0] = 1'b0;
        // R4 source enable
        wreg(2'd0, 8'h9E);
        expect_irq("R4 ext0 disabled", 1'b1, 16'h000B);
        // R7 high level wins
        wreg(2'd1, 8'h08);
        expect_irq("R7 timer1 high", 1'b1, 16'h001B);
        ack = 1; cyc();
        expect_irq("R8 high busy", 1'b0, 16'h0000);
        reti = 1; cyc();
        expect_irq("R11 R9 timer1 retired", 1'b1, 16'h000B);
        ack = 1; cyc();
        expect_irq("R8 low busy blocks low", 1'b0, 16'h0000);
        wreg(2'd1, 8'h10);
        expect_irq("R8 high preempts low", 1'b1, 16'h0023);
        ack = 1; cyc();
        expect_irq("R8 nested high busy", 1'b0, 16'h0000);
        addr = 2'd2; #0.1; chk("R10 ack keeps serial flag", 32'(rdata), 32'h01);
        reti = 1; cyc();
        expect_irq("R11 high retired first", 1'b1, 16'h0023);
        wreg(2'd1, 8'h00);
        expect_irq("R11 low still active", 1'b0, 16'h0000);
        reti = 1; cyc();
        expect_irq("R11 low retired", 1'b1, 16'h0023);
        wreg(2'd2, 8'h01);
        expect_irq("R10 clear by write", 1'b0, 16'h0000);
        addr = 2'd2; #0.1; chk("R10 flag cleared", 32'(rdata), 32'h00);
        tx = 1; cyc();
        expect_irq("R10 transmit shares vector", 1'b1, 16'h0023);
        rx = 1; addr = 2'd2; wdata = 8'h01; wr = 1; cyc();
        addr = 2'd2; #0.1; chk("R10 set beats clear", 32'(rdata), 32'h03);
        wreg(2'd2, 8'h03);
        // R9 level source
        ext_irq[1] = 1'b1; cyc();
        expect_irq("R9 level ext1", 1'b1, 16'h0013);
        ack = 1; cyc();
        reti = 1; cyc();
        expect_irq("R9 level still high", 1'b1, 16'h0013);
        ext_irq[1] = 1'b0; cyc();
        expect_irq("R9 level dropped", 1'b0, 16'h0000);
        // R9 / R12 edge source
        wreg(2'd0, 8'h9F);
        expect_irq("R12 ext0 held pending", 1'b1, 16'h0003);
        ack = 1; cyc(); reti = 1; cyc();
        expect_irq("R9 edge flag cleared", 1'b0, 16'h0000);
        ext_irq[0] = 1'b1; cyc();
        expect_irq("R12 new rise", 1'b1, 16'h0003);
        ack = 1; cyc(); reti = 1; cyc();
        expect_irq("R12 held high no rearm", 1'b0, 16'h0000);
        ext_irq = 0; cyc();
        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 7) == 0) ext_irq[0] = ~ext_irq[0];
            if ($urandom_range(0, 7) == 0) ext_irq[1] = ~ext_irq[1];
            tmr_ovf = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
            rx = ($urandom_range(0, 15) == 0);
            tx = ($urandom_range(0, 15) == 0);
            addr = 2'($urandom);
            wdata = 8'($urandom);
            wr = ($urandom_range(0, 9) == 0);
            if (wr && addr == 2'd0 && $urandom_range(0, 3) != 0) wdata[7] = 1'b1;
            ack = req && ($urandom_range(0, 1) == 1);
            reti = !ack && ($urandom_range(0, 5) == 0);
            step();
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule